// File: doc/BRIEF.md
# In-Order Issue Scoreboard

This block sits at the issue stage of an in-order pipeline and answers a single question each cycle. May the decoded instruction now at the head of the stage go to its functional unit? It tracks two things. The first is one busy flag for each of four unit classes: integer, add, multiply and divide. The second is one write-pending flag for each architectural register. An instruction is held back if its unit is occupied or if it touches a register that still has a write outstanding.

The grant is combinational from the presented instruction and the current flags. When an instruction is granted, two flags are set and take effect on the next clock edge: its unit becomes busy, and its destination becomes write-pending. A unit reports its end of occupancy with a free pulse. A unit can also hold itself off for the current cycle. A writeback notification clears the write-pending flag of its register. There is no check for a later write overtaking an earlier read, because with issue in program order that case cannot arise.

Top module: `issue_scoreboard`

## Requirements
- R1: `rst` is synchronous and active high. While it is high, `issueGrant` is 0. It clears every busy and write-pending flag, so that after its release an instruction that was blocked only by earlier state is granted.
- R2: `issueGrant` is 1 only when `instValid` is 1, and at most one instruction is granted per cycle. `issueUnit` is one-hot with bit `instClass` set during a grant, and all zeros otherwise. The class encoding is 0 integer, 1 add, 2 multiply, 3 divide.
- R3: A grant makes its unit class busy from the next cycle. The busy flag is cleared by a pulse on `fuFree[class]`, and this takes effect the cycle after the pulse. An instruction of a busy class is not granted. If a free pulse and a grant for the same class fall in one cycle, the class ends up busy.
- R4: `fuHold[class]` high blocks a grant to that class in the same cycle, and it leaves no state behind.
- R5: The instruction is not granted if the write-pending flag of `instSrc1` or of `instSrc2` is set.
- R6: When `instHasDest` is 1, the instruction is not granted if the write-pending flag of `instDest` is set. When `instHasDest` is 0, `instDest` is not looked at.
- R7: A register that is only read by an instruction already issued does not block a later instruction that writes it.
- R8: A grant with `instHasDest`=1 and a nonzero `instDest` sets that register's write-pending flag, which is visible from the next cycle.
- R9: `wbValid` clears the write-pending flag of `wbReg`, and this is visible from the next cycle. If a grant sets the same register in the same cycle, the register stays pending.
- R10: Register 0 is never write-pending. A grant writing register 0 has no effect on later instructions, and neither does a writeback to register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | A decoded instruction is presented |
| instClass | input | 2 | Unit class required (0 int, 1 add, 2 mul, 3 div) |
| instHasDest | input | 1 | Instruction writes a register |
| instDest | input | REG_W | Destination register index |
| instSrc1 | input | REG_W | First source register index |
| instSrc2 | input | REG_W | Second source register index |
| fuHold | input | 4 | Per-class hold-off for the current cycle |
| fuFree | input | 4 | Per-class end-of-occupancy pulse |
| wbValid | input | 1 | A writeback is reported this cycle |
| wbReg | input | REG_W | Register being written back |
| issueGrant | output | 1 | Instruction may issue this cycle |
| issueUnit | output | 4 | One-hot selected unit class |

## Verification
The assertions check the properties that can be seen at the ports in any two adjacent cycles, on every cycle:
- a grant never occurs without a valid instruction;
- `issueUnit` is one-hot and agrees with the grant;
- a held unit is never granted;
- a back-to-back request for the unit just granted is refused;
- a read or a rewrite of the destination just granted is refused in the following cycle.

Some orderings are visible only in the bench's scenarios, which compare each cycle against a behavioural model:
- a writeback releasing a register, and the set winning over a writeback in the same cycle;
- a free pulse taking one cycle to release a unit;
- register 0 and destination-less instructions leaving no trace;
- reset clearing flags that were left dirty.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_UNITS = 4;
  localparam int CLS_W     = $clog2(NUM_UNITS);

  typedef enum logic [CLS_W-1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unitClass_e;

  // strobes from control to the flag datapath
  typedef struct packed {
    logic                 grant;
    logic [NUM_UNITS-1:0] unitSel;
    logic                 markPend;
  } sbStrobe_t;
endpackage

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                 rst,
  input  logic                 instValid,
  input  logic [CLS_W-1:0]     instClass,
  input  logic                 instHasDest,
  input  logic [REG_W-1:0]     instDest,
  input  logic [REG_W-1:0]     instSrc1,
  input  logic [REG_W-1:0]     instSrc2,
  input  logic [NUM_UNITS-1:0] fuHold,
  input  logic [NUM_REGS-1:0]  pendVec,
  input  logic [NUM_UNITS-1:0] busyVec,
  output sbStrobe_t            strobe
);
  logic [NUM_UNITS-1:0] reqUnit;
  logic unitBlocked;
  logic rawHaz;
  logic wawHaz;
  logic grantNow;

  // decode the requested class to a one-hot unit vector
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_dec
    assign reqUnit[u] = (instClass == CLS_W'(u));
  end

  assign unitBlocked = |(reqUnit & (busyVec | fuHold));
  assign rawHaz      = pendVec[instSrc1] | pendVec[instSrc2];
  assign wawHaz      = instHasDest & pendVec[instDest];
  assign grantNow    = !rst && instValid && !unitBlocked && !rawHaz && !wawHaz;

  always_comb begin
    strobe.grant    = grantNow;
    strobe.unitSel  = grantNow ? reqUnit : '0;
    strobe.markPend = grantNow && instHasDest && (instDest != '0);
  end
endmodule

// File: rtl/sb_state.sv
module sb_state
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  sbStrobe_t            strobe,
  input  logic [REG_W-1:0]     instDest,
  input  logic [NUM_UNITS-1:0] fuFree,
  input  logic                 wbValid,
  input  logic [REG_W-1:0]     wbReg,
  output logic [NUM_REGS-1:0]  pendVec,
  output logic [NUM_UNITS-1:0] busyVec
);
  // write-pending flags, register 0 hardwired clear
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_pend
    if (r == 0) begin : g_zero
      assign pendVec[r] = 1'b0;
    end else begin : g_flag
      logic pendQ;
      always_ff @(posedge clk) begin
        if (rst)                                          pendQ <= 1'b0;
        else if (strobe.markPend && instDest == REG_W'(r)) pendQ <= 1'b1;
        else if (wbValid && wbReg == REG_W'(r))            pendQ <= 1'b0;
      end
      assign pendVec[r] = pendQ;
    end
  end

  // unit occupancy flags, set on grant wins over a free pulse
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_busy
    logic busyQ;
    always_ff @(posedge clk) begin
      if (rst)                    busyQ <= 1'b0;
      else if (strobe.unitSel[u]) busyQ <= 1'b1;
      else if (fuFree[u])         busyQ <= 1'b0;
    end
    assign busyVec[u] = busyQ;
  end
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 instValid,
  input  logic [CLS_W-1:0]     instClass,
  input  logic                 instHasDest,
  input  logic [REG_W-1:0]     instDest,
  input  logic [REG_W-1:0]     instSrc1,
  input  logic [REG_W-1:0]     instSrc2,
  input  logic [NUM_UNITS-1:0] fuHold,
  input  logic [NUM_UNITS-1:0] fuFree,
  input  logic                 wbValid,
  input  logic [REG_W-1:0]     wbReg,
  output logic                 issueGrant,
  output logic [NUM_UNITS-1:0] issueUnit
);
  sbStrobe_t            strobe;
  logic [NUM_REGS-1:0]  pendVec;
  logic [NUM_UNITS-1:0] busyVec;

  sb_ctrl #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_ctrl (
    .rst(rst), .instValid(instValid), .instClass(instClass),
    .instHasDest(instHasDest), .instDest(instDest),
    .instSrc1(instSrc1), .instSrc2(instSrc2), .fuHold(fuHold),
    .pendVec(pendVec), .busyVec(busyVec), .strobe(strobe)
  );

  sb_state #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_state (
    .clk(clk), .rst(rst), .strobe(strobe), .instDest(instDest),
    .fuFree(fuFree), .wbValid(wbValid), .wbReg(wbReg),
    .pendVec(pendVec), .busyVec(busyVec)
  );

  assign issueGrant = strobe.grant;
  assign issueUnit  = strobe.unitSel;
endmodule

// File: rtl/sb_chk.sv
module sb_chk
  import sb_pkg::*;
#(
  parameter int REG_W = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 instValid,
  input logic [CLS_W-1:0]     instClass,
  input logic                 instHasDest,
  input logic [REG_W-1:0]     instDest,
  input logic [REG_W-1:0]     instSrc1,
  input logic [NUM_UNITS-1:0] fuHold,
  input logic                 issueGrant,
  input logic [NUM_UNITS-1:0] issueUnit
);
  // R2
  grant_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    issueGrant |-> instValid);

  // R2
  unit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(issueUnit) && ((issueUnit != '0) == issueGrant));

  // R4
  hold_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (instValid && fuHold[instClass]) |-> !issueGrant);

  // R3
  busy_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    issueGrant ##1 (instValid && instClass == $past(instClass)) |-> !issueGrant);

  // R5
  raw_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (issueGrant && instHasDest && instDest != '0)
      ##1 (instValid && instSrc1 == $past(instDest)) |-> !issueGrant);

  // R6
  waw_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (issueGrant && instHasDest && instDest != '0)
      ##1 (instValid && instHasDest && instDest == $past(instDest)) |-> !issueGrant);
endmodule

bind issue_scoreboard sb_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .instValid(instValid), .instClass(instClass),
  .instHasDest(instHasDest), .instDest(instDest), .instSrc1(instSrc1),
  .fuHold(fuHold), .issueGrant(issueGrant), .issueUnit(issueUnit)
);

// File: tb/tb_issue_scoreboard.sv
module tb_issue_scoreboard;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instValid = 1'b0;
  logic [1:0] instClass = '0;
  logic instHasDest = 1'b0;
  logic [RW-1:0] instDest = '0, instSrc1 = '0, instSrc2 = '0;
  logic [3:0] fuHold = '0, fuFree = '0;
  logic wbValid = 1'b0;
  logic [RW-1:0] wbReg = '0;
  logic issueGrant;
  logic [3:0] issueUnit;

  int total = 0;
  int bad = 0;
  bit pendM[NREG];
  bit busyM[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_scoreboard #(.NUM_REGS(NREG), .REG_W(RW)) dut (
    .clk(clk), .rst(rst), .instValid(instValid), .instClass(instClass),
    .instHasDest(instHasDest), .instDest(instDest), .instSrc1(instSrc1),
    .instSrc2(instSrc2), .fuHold(fuHold), .fuFree(fuFree),
    .wbValid(wbValid), .wbReg(wbReg), .issueGrant(issueGrant),
    .issueUnit(issueUnit)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input bit r, input bit v, input int c,
                      input bit hd, input int d, input int s1, input int s2,
                      input int hold, input int free, input bit wv, input int wr,
                      input int expG);
    bit mg;
    int mu;
    @(negedge clk);
    rst = r; instValid = v; instClass = 2'(c); instHasDest = hd;
    instDest = RW'(d); instSrc1 = RW'(s1); instSrc2 = RW'(s2);
    fuHold = 4'(hold); fuFree = 4'(free); wbValid = wv; wbReg = RW'(wr);
    #1;
    mg = !r && v && !busyM[c] && !hold[c] && !pendM[s1] && !pendM[s2]
         && !(hd && pendM[d]);
    mu = mg ? (1 << c) : 0;
    check(tag, int'(issueGrant), int'(mg));
    check(tag, int'(issueUnit), mu);
    if (expG >= 0) check(tag, int'(issueGrant), expG);
    if (r) begin
      foreach (pendM[i]) pendM[i] = 0;
      foreach (busyM[i]) busyM[i] = 0;
    end else begin
      for (int u = 0; u < 4; u++) if (free[u]) busyM[u] = 0;
      if (mg) busyM[c] = 1;
      if (wv && wr != 0) pendM[wr] = 0;
      if (mg && hd && d != 0) pendM[d] = 1;
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (pendM[i]) pendM[i] = 0;
    foreach (busyM[i]) busyM[i] = 0;
    // R1 grant held low during reset
    step("R1", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R1", 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 1, 0, 1, 5, 0, 0, 0, 15, 0, 0, 1);
    step("R1", 1, 1, 1, 0, 0, 5, 0, 0, 15, 0, 0, 0);
    step("R1", 0, 1, 1, 0, 0, 5, 0, 0, 15, 0, 0, 1);
    step("R8", 0, 1, 2, 1, 7, 0, 0, 0, 15, 0, 0, 1);
    step("R5", 0, 1, 3, 0, 0, 7, 0, 0, 15, 0, 0, 0);
    step("R5", 0, 1, 0, 0, 0, 0, 7, 0, 15, 0, 0, 0);
    step("R6", 0, 1, 1, 1, 7, 0, 0, 0, 15, 0, 0, 0);
    step("R6", 0, 1, 1, 0, 7, 0, 0, 0, 0, 0, 0, 1);
    step("R2", 0, 1, 3, 1, 8, 0, 0, 0, 15, 0, 0, 1);
    step("R3", 0, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 1, 3, 0, 0, 0, 0, 0, 8, 0, 0, 0);
    step("R3", 0, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R4", 0, 1, 0, 0, 0, 0, 0, 1, 15, 0, 0, 0);
    step("R4", 0, 1, 0, 0, 0, 0, 0, 0, 15, 0, 0, 1);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 15, 1, 7, 0);
    step("R9", 0, 1, 1, 0, 0, 7, 0, 0, 15, 0, 0, 1);
    step("R9", 0, 1, 2, 1, 12, 0, 0, 0, 15, 1, 12, 1);
    step("R9", 0, 1, 0, 0, 0, 12, 0, 0, 15, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 15, 1, 12, 0);
    step("R10", 0, 1, 1, 1, 0, 0, 0, 0, 15, 1, 0, 1);
    step("R10", 0, 1, 0, 1, 0, 0, 0, 0, 15, 0, 0, 1);
    step("R7", 0, 1, 3, 1, 21, 20, 0, 0, 15, 0, 0, 1);
    step("R7", 0, 1, 2, 1, 20, 0, 0, 0, 15, 0, 0, 1);
    // randomized traffic compared each cycle with the model
    for (int n = 0; n < 2000; n++) begin
      step("R2", ($urandom_range(0, 199) == 0), ($urandom_range(0, 3) != 0),
           $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 7),
           $urandom_range(0, 7), $urandom_range(0, 7),
           ($urandom_range(0, 5) == 0) ? $urandom_range(0, 15) : 0,
           $urandom_range(0, 15), $urandom_range(0, 1), $urandom_range(0, 7), -1);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule